// File: doc/BRIEF.md
# ADC Sample Aligner and Frame Packer

This block sits behind a fast 14-bit analog-to-digital converter in a pixel-sensor readout chain. It latches the converter's output bus on the clock edge the system picks, lines the samples up with the readout timing strobes, and merges everything into one 16-bit word stream. The converter reports each sample several cycles after the timing logic requested it. To make up for this, the frame, row and sample-enable strobes pass through a delay of selectable length before they are paired with the data.

Each sample that arrives while the delayed enable is high becomes a data word. Each delayed frame or row strobe becomes a header word that carries the running frame and row indices. Software can therefore split the stream back into frames and rows. The stream uses a valid/ready handshake. A word that cannot be delivered because the consumer is stalled is lost and recorded in a sticky flag, which a clear pulse resets. At one word per 100 MHz cycle the stream has ample margin over the 40 MB/s (20 Mword/s) the memory path needs.

Top module: `adc_frame_packer`

## Requirements
- R1: After reset `out_valid` and `overflow` are 0, and the frame and row indices are 0.
- R2: With `edge_sel`=0 the bus is latched on the rising clock edge. With `edge_sel`=1 it is latched on the falling edge that comes before that rising edge.
- R3: The three strobes are delayed by `tap_sel`+1 cycles, so `tap_sel`=0 is one stage and 15 is sixteen. An enable given in cycle T is therefore paired with the sample presented in cycle T+`tap_sel`.
- R4: A data word has bit 15 = 0 and bit 14 = 0, and bits 13:0 hold the sample.
- R5: A delayed frame strobe emits a header with bits 15:14 = 2'b11, bits 13:8 = the frame index plus one, and bits 7:0 = 0. The frame index then takes that new value and the row index becomes 0.
- R6: A delayed row strobe emits a header with bits 15:14 = 2'b10, bits 13:8 = the current frame index, and bits 7:0 = the row index plus one. The row index then takes that new value.
- R7: At most one word is produced per cycle. The frame strobe wins over the row strobe, which wins over a sample, and a losing strobe or sample has no effect.
- R8: No word is emitted while all three delayed strobes are low, whatever the bus does.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` is unchanged.
- R10: A new word that comes while the output is stalled is dropped and sets `overflow`. The flag stays set until a cycle with `ovf_clear`=1 and no new drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture and stream clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_data | input | 14 | Converter output bus |
| edge_sel | input | 1 | 0: latch on rising edge, 1: latch on falling edge |
| tap_sel | input | 4 | Strobe delay minus one |
| frame_strobe | input | 1 | Start of a new frame |
| row_strobe | input | 1 | Start of a new row |
| sample_en | input | 1 | Sample belongs to the image |
| out_valid | output | 1 | Output word present |
| out_data | output | 16 | Header or data word |
| out_ready | input | 1 | Consumer accepts the word |
| ovf_clear | input | 1 | Clears the overflow flag |
| overflow | output | 1 | Sticky record of a dropped word |

## Verification
The bench builds the block with its default parameters: 14-bit samples, 16 delay stages, a 6-bit frame index and an 8-bit row index. This lets it exercise the shortest delay, a middle delay and the full sixteen-stage delay against a ramp on the bus, and compare both capture edges with a bus that changes between the falling and the rising edge. It also covers coincident strobes and the stall-and-drop path at the exact widths of the header fields.

// File: rtl/adc_frame_packer.sv
module adc_frame_packer #(
  parameter int SAMPLE_W = 14,
  parameter int WORD_W   = 16,
  parameter int MAX_TAPS = 16,
  parameter int FRAME_W  = 6,
  parameter int ROW_W    = 8,
  localparam int TAP_W   = $clog2(MAX_TAPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] adc_data,
  input  logic                edge_sel,
  input  logic [TAP_W-1:0]    tap_sel,
  input  logic                frame_strobe,
  input  logic                row_strobe,
  input  logic                sample_en,
  output logic                out_valid,
  output logic [WORD_W-1:0]   out_data,
  input  logic                out_ready,
  input  logic                ovf_clear,
  output logic                overflow
);
  localparam int PAD_W = WORD_W - SAMPLE_W;

  logic [SAMPLE_W-1:0] fall_q, cap_q;
  logic [2:0]          pipe [MAX_TAPS];
  logic [FRAME_W-1:0]  frame_cnt;
  logic [ROW_W-1:0]    row_cnt;
  logic                has_new;
  logic [WORD_W-1:0]   new_word;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) fall_q <= '0;
    else        fall_q <= adc_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cap_q <= '0;
    else        cap_q <= edge_sel ? fall_q : adc_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < MAX_TAPS; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= {frame_strobe, row_strobe, sample_en};
      for (int i = 1; i < MAX_TAPS; i++) pipe[i] <= pipe[i-1];
    end

  wire [2:0] sel = pipe[tap_sel];
  wire s_frame = sel[2];
  wire s_row   = sel[1];
  wire s_en    = sel[0];
  wire stall   = out_valid && !out_ready;

  always_comb begin
    has_new  = 1'b1;
    new_word = '0;
    if (s_frame)    new_word = {2'b11, frame_cnt + 1'b1, {ROW_W{1'b0}}};
    else if (s_row) new_word = {2'b10, frame_cnt, row_cnt + 1'b1};
    else if (s_en)  new_word = {{PAD_W{1'b0}}, cap_q};
    else            has_new  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      frame_cnt <= '0;
      row_cnt   <= '0;
    end else if (s_frame) begin
      frame_cnt <= frame_cnt + 1'b1;
      row_cnt   <= '0;
    end else if (s_row) begin
      row_cnt   <= row_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      overflow  <= 1'b0;
    end else begin
      if (!stall) begin
        out_valid <= has_new;
        if (has_new) out_data <= new_word;
      end
      if (stall && has_new) overflow <= 1'b1;
      else if (ovf_clear)   overflow <= 1'b0;
    end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9
  AST_FRAME_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    s_frame && !stall |=> out_valid && out_data[WORD_W-1 -: 2] == 2'b11); // R5
  AST_DATA_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_data[WORD_W-1] |-> out_data[WORD_W-2] == 1'b0); // R4
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    stall && has_new |=> overflow); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !ovf_clear |=> overflow); // R10
  AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !s_frame && !s_row && !s_en && !stall |=> !out_valid); // R8
endmodule

// File: tb/tb_adc_frame_packer.sv
module tb_adc_frame_packer;
  logic        clk = 0, rst_n = 0;
  logic [13:0] adc_data = '0;
  logic        edge_sel = 0;
  logic [3:0]  tap_sel = 0;
  logic        frame_strobe = 0, row_strobe = 0, sample_en = 0;
  logic        out_valid, overflow;
  logic [15:0] out_data;
  logic        out_ready = 1, ovf_clear = 0;

  int n_chk = 0, n_fail = 0, got_n = 0;
  logic [15:0] got [0:255];
  bit done = 0;

  always #5 clk = ~clk;

  adc_frame_packer dut (
    .clk(clk), .rst_n(rst_n), .adc_data(adc_data), .edge_sel(edge_sel),
    .tap_sel(tap_sel), .frame_strobe(frame_strobe), .row_strobe(row_strobe),
    .sample_en(sample_en), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .ovf_clear(ovf_clear), .overflow(overflow));

  always @(negedge clk)
    if (rst_n && out_valid && out_ready && got_n < 256) begin
      got[got_n] = out_data;
      got_n++;
    end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_word(input int idx, input logic [15:0] exp, input string req);
    if (idx >= got_n) check(0, req, -1, exp);
    else check(got[idx] == exp, req, got[idx], exp);
  endtask

  task automatic step(input bit f, input bit r, input bit e,
                      input logic [13:0] d_early, input logic [13:0] d_late);
    @(posedge clk); #1;
    frame_strobe = f; row_strobe = r; sample_en = e; adc_data = d_early;
    #5 adc_data = d_late;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 14'h3FFF, 14'h2AAA);
  endtask

  task automatic t_reset;
    #2;
    check(out_valid == 0, "R1 valid", out_valid, 0);
    check(overflow == 0, "R1 overflow", overflow, 0);
    rst_n = 1;
  endtask

  task automatic t_edges;
    int base = got_n;
    edge_sel = 0;
    step(0, 0, 1, 14'h0111, 14'h1234);
    step(0, 0, 1, 14'h0222, 14'h0ABC);
    idle(4);
    check_word(base,     16'h1234, "R2 rise");
    check_word(base + 1, 16'h0ABC, "R2 rise / R4 zext");
    base = got_n;
    edge_sel = 1;
    step(0, 0, 1, 14'h0111, 14'h1234);
    step(0, 0, 1, 14'h3222, 14'h0ABC);
    idle(4);
    check_word(base,     16'h0111, "R2 fall");
    check_word(base + 1, 16'h3222, "R2 fall / R4 zext");
    check(got_n == base + 2, "R2 count", got_n - base, 2);
    edge_sel = 0;
  endtask

  task automatic t_tap(input int k);
    int base = got_n;
    tap_sel = 4'(k);
    for (int i = 0; i < 20; i++)
      step(0, 0, i == 2, 14'(16'h100 + i), 14'(16'h100 + i));
    idle(4);
    check(got_n == base + 1, "R3 count", got_n - base, 1);
    check_word(base, 16'(16'h100 + 2 + k), "R3 tap");
    tap_sel = 0;
  endtask

  task automatic t_gating;
    int base = got_n;
    for (int i = 0; i < 20; i++) step(0, 0, 0, 14'(i * 37), 14'(i * 91));
    check(got_n == base, "R8 no words", got_n - base, 0);
    check(out_valid == 0, "R8 valid low", out_valid, 0);
  endtask

  task automatic t_headers;
    int base = got_n;
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(0, 0, 1, 14'h0055, 14'h0055);
    step(0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    idle(4);
    check_word(base,     16'hC100, "R5 first frame");
    check_word(base + 1, 16'h8101, "R6 row 1");
    check_word(base + 2, 16'h0055, "R4 data");
    check_word(base + 3, 16'h8102, "R6 row 2");
    check_word(base + 4, 16'h8103, "R6 row 3");
    check_word(base + 5, 16'hC200, "R5 second frame");
    check_word(base + 6, 16'h8201, "R6 row after frame");
  endtask

  task automatic t_priority;
    int base = got_n;
    step(1, 1, 1, 14'h0777, 14'h0777);
    step(0, 1, 1, 14'h0666, 14'h0666);
    step(0, 0, 1, 14'h0444, 14'h0444);
    idle(4);
    check(got_n == base + 3, "R7 one word per cycle", got_n - base, 3);
    check_word(base,     16'hC300, "R7 frame wins");
    check_word(base + 1, 16'h8301, "R7 row wins, row reset");
    check_word(base + 2, 16'h0444, "R7 sample");
  endtask

  task automatic t_stall;
    int base = got_n;
    out_ready = 0;
    step(0, 0, 1, 14'h0ABC, 14'h0ABC);
    idle(2);
    check(out_valid == 1 && out_data == 16'h0ABC, "R9 held", out_data, 16'h0ABC);
    idle(3);
    check(out_valid == 1 && out_data == 16'h0ABC, "R9 stable", out_data, 16'h0ABC);
    check(overflow == 0, "R10 no drop yet", overflow, 0);
    @(posedge clk); #1; out_ready = 1;
    idle(3);
    check(got_n == base + 1, "R9 single accept", got_n - base, 1);
    check_word(base, 16'h0ABC, "R9 word");
  endtask

  task automatic t_overflow;
    int base = got_n;
    out_ready = 0;
    step(0, 0, 1, 14'h0101, 14'h0101);
    step(0, 0, 1, 14'h0202, 14'h0202);
    idle(3);
    check(overflow == 1, "R10 set", overflow, 1);
    check(out_data == 16'h0101, "R10 first kept", out_data, 16'h0101);
    @(posedge clk); #1; out_ready = 1;
    idle(5);
    check(got_n == base + 1, "R10 second dropped", got_n - base, 1);
    check(overflow == 1, "R10 sticky", overflow, 1);
    @(posedge clk); #1; ovf_clear = 1;
    @(posedge clk); #1; ovf_clear = 0;
    #3 check(overflow == 0, "R10 cleared", overflow, 0);
  endtask

  initial begin
    t_reset();
    idle(2);
    t_edges();
    t_tap(0);
    t_tap(5);
    t_tap(15);
    t_gating();
    t_headers();
    t_priority();
    t_stall();
    t_overflow();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule